// File: doc/BRIEF.md
# Configurable Registered Address/Command Buffer with Cascadable Parity

This block is the clocked address/command register of a registered memory module. On each rising clock edge it captures a bank of input bits and drives them to a registered output bus. A static layout input selects one of two fan-out shapes. In the wide layout, 25 inputs each drive one output. In the split layout, the low 14 inputs each drive two outputs, one in the lower half of the bus and one in the upper half. Two active-low chip-select inputs gate the output register. When neither is asserted, the outputs keep their previous values.

The block also checks even parity over a fixed, per-layout subset of the inputs. Lines such as clock enable, termination control and chip selects are left out of that subset. The parity bit from the controller arrives one clock after its data word. A role input lets two devices share one check. The first device exports its partial parity and never flags an error. The second device folds the incoming partial parity into its own sum and drives the error flag. The error flag models an open-drain pin as a pair of outputs: an active-low level and an output enable. The flag is asserted for two cycles on each mismatch.

Top module: `cfg_regbuf`

## Requirements
- R1: A synchronous active-high reset clears the output bus and the partial parity output to 0, and releases the error flag (err_oe=0, err_n=1).
- R2: With cfg_layout=0 (wide), output bit i equals input bit i as captured at the previous clock edge, for i in 0..24, and output bits 27..25 are 0.
- R3: With cfg_layout=1 (split), output bits i and i+14 both equal input bit i as captured at the previous edge, for i in 0..13. Input bits 24..14 do not reach any output.
- R4: At an edge where both cs_n bits are 1, the output bus keeps its value. If either bit is 0, the bus loads the new word.
- R5: The parity bit for a word captured at edge k is sampled at edge k+1. ppar_out, updated at edge k+1, is the XOR of the parity-checked bits of that word and par_in. The checked bits are 21..0 in the wide layout and 11..0 in the split layout.
- R6: In the second role, a mismatch for the word captured at edge k sets err_oe=1 and err_n=0 from edge k+2 for exactly two cycles. A new mismatch while the flag is active restarts the two-cycle window.
- R7: Input bits outside the checked set (24..22 in the wide layout, 24..12 in the split layout) never affect ppar_out or the error flag.
- R8: With cfg_role=0 (first role), err_oe stays 0 whatever the parity, while ppar_out still follows R5.
- R9: With cfg_role=1 (second role), the mismatch test at edge k+2 is ppar_out XOR ppar_in, where ppar_in is the first device's partial parity. ppar_in tied to 0 gives a standalone check.
- R10: After reset, no error is raised until the first data word and its parity bit have both been sampled. The value par_in carries at the first edge after reset, which pairs with no captured word, is not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_layout | input | 1 | 0 = wide 1:1 layout, 1 = split 1:2 layout |
| cfg_role | input | 1 | 0 = first device of a pair, 1 = second / standalone checker |
| cs_n | input | 2 | Active-low chip selects gating output updates |
| d | input | 25 | Captured address/command inputs |
| par_in | input | 1 | Controller parity bit, one cycle after its word |
| ppar_in | input | 1 | Partial parity from the first device of a pair |
| q | output | 28 | Registered outputs |
| ppar_out | output | 1 | Registered partial parity |
| err_n | output | 1 | Active-low parity error level |
| err_oe | output | 1 | Drive enable for err_n; high only while an error is flagged |

## Verification
The hardest situations to reach from the ports are those where the one-cycle parity skew meets a boundary. These are: the first edge after reset, where par_in pairs with no captured word; back-to-back mismatches that must restart the hold window; and the cascade, where ppar_in must cancel or create a mismatch two edges after the data. The stimulus drives par_in with a pipeline that always carries the parity owed for the previous word. A per-word corruption flag lets single, consecutive and paired errors be placed exactly. The bench forces a stale parity value in the reset-release cycle. It drives ppar_in high across a stretch of deliberately odd words, so the cascade must cancel each error.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  typedef enum logic {
    LAYOUT_WIDE = 1'b0,
    LAYOUT_DUAL = 1'b1
  } layout_e;

  typedef enum logic {
    ROLE_FIRST  = 1'b0,
    ROLE_SECOND = 1'b1
  } role_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/regbuf_capture.sv
module regbuf_capture
  import regbuf_pkg::*;
#(
  parameter int IN_W   = 25,
  parameter int DUAL_W = 14,
  parameter int CS_W   = 2,
  parameter int OUT_W  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  layout_e           layout,
  input  logic [CS_W-1:0]   cs_n,
  input  logic [IN_W-1:0]   d,
  output logic [OUT_W-1:0]  q,
  output logic [IN_W-1:0]   d_hold
);

  logic [OUT_W-1:0] fan;

  // Per-output source selection; structure depends on the layout widths.
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    logic wide_b;
    logic dual_b;
    if (i < IN_W) begin : g_wide
      assign wide_b = d[i];
    end else begin : g_wide_pad
      assign wide_b = 1'b0;
    end
    if (i < 2 * DUAL_W) begin : g_dual
      assign dual_b = d[i % DUAL_W];
    end else begin : g_dual_pad
      assign dual_b = 1'b0;
    end
    assign fan[i] = (layout == LAYOUT_DUAL) ? dual_b : wide_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      d_hold <= '0;
    end else begin
      d_hold <= d;
      if (!(&cs_n)) q <= fan;
    end
  end

endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity
  import regbuf_pkg::*;
#(
  parameter int              IN_W      = 25,
  parameter logic [IN_W-1:0] MASK_WIDE = '1,
  parameter logic [IN_W-1:0] MASK_DUAL = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  layout_e         layout,
  input  role_e           role,
  input  logic [IN_W-1:0] d_hold,
  input  logic            par_in,
  input  logic            ppar_in,
  output logic            ppar_out,
  output logic            mismatch
);

  logic [IN_W-1:0] sel_mask;
  logic            own_par;
  logic            sum_r;
  logic            word_vld_r;
  logic            pair_vld_r;

  assign sel_mask = (layout == LAYOUT_DUAL) ? MASK_DUAL : MASK_WIDE;
  assign own_par  = ^(d_hold & sel_mask);

  // Stage 1 (edge k+1): word captured at edge k meets its parity bit.
  // Stage 2 (edge k+2): combined with the neighbour's partial parity.
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_r      <= 1'b0;
      word_vld_r <= 1'b0;
      pair_vld_r <= 1'b0;
    end else begin
      sum_r      <= own_par ^ par_in;
      word_vld_r <= 1'b1;
      pair_vld_r <= word_vld_r;
    end
  end

  assign ppar_out = sum_r;
  assign mismatch = pair_vld_r & (role == ROLE_SECOND) & (sum_r ^ ppar_in);

endmodule

// File: rtl/regbuf_errhold.sv
module regbuf_errhold #(
  parameter int HOLD = 2,
  localparam int CNT_W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic mismatch,
  output logic err_n,
  output logic err_oe
);

  logic [CNT_W-1:0] cnt_r;

  always_ff @(posedge clk) begin
    if (rst)              cnt_r <= '0;
    else if (mismatch)    cnt_r <= CNT_W'(HOLD);
    else if (cnt_r != '0) cnt_r <= cnt_r - 1'b1;
  end

  assign err_oe = (cnt_r != '0);
  assign err_n  = ~err_oe;

endmodule

// File: rtl/cfg_regbuf.sv
module cfg_regbuf
  import regbuf_pkg::*;
#(
  parameter int              IN_W      = 25,
  parameter int              DUAL_W    = 14,
  parameter int              CS_W      = 2,
  parameter int              ERR_HOLD  = 2,
  parameter logic [IN_W-1:0] MASK_WIDE = 25'h03F_FFFF,
  parameter logic [IN_W-1:0] MASK_DUAL = 25'h000_0FFF,
  localparam int             OUT_W     = max_u(IN_W, 2 * DUAL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_layout,
  input  logic             cfg_role,
  input  logic [CS_W-1:0]  cs_n,
  input  logic [IN_W-1:0]  d,
  input  logic             par_in,
  input  logic             ppar_in,
  output logic [OUT_W-1:0] q,
  output logic             ppar_out,
  output logic             err_n,
  output logic             err_oe
);

  layout_e         layout;
  role_e           role;
  logic [IN_W-1:0] d_hold;
  logic            mismatch;

  assign layout = layout_e'(cfg_layout);
  assign role   = role_e'(cfg_role);

  regbuf_capture #(
    .IN_W(IN_W), .DUAL_W(DUAL_W), .CS_W(CS_W), .OUT_W(OUT_W)
  ) u_capture (
    .clk(clk), .rst(rst), .layout(layout), .cs_n(cs_n),
    .d(d), .q(q), .d_hold(d_hold)
  );

  regbuf_parity #(
    .IN_W(IN_W), .MASK_WIDE(MASK_WIDE), .MASK_DUAL(MASK_DUAL)
  ) u_parity (
    .clk(clk), .rst(rst), .layout(layout), .role(role),
    .d_hold(d_hold), .par_in(par_in), .ppar_in(ppar_in),
    .ppar_out(ppar_out), .mismatch(mismatch)
  );

  regbuf_errhold #(
    .HOLD(ERR_HOLD)
  ) u_errhold (
    .clk(clk), .rst(rst), .mismatch(mismatch),
    .err_n(err_n), .err_oe(err_oe)
  );

endmodule

// File: rtl/regbuf_checker.sv
module regbuf_checker #(
  parameter int CS_W  = 2,
  parameter int OUT_W = 28,
  parameter int IN_W  = 25,
  parameter int DUAL_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_layout,
  input logic             cfg_role,
  input logic [CS_W-1:0]  cs_n,
  input logic [OUT_W-1:0] q,
  input logic             ppar_out,
  input logic             err_oe
);

  logic past_rst = 1'b0;

  always_ff @(posedge clk) past_rst <= rst;

  always @(posedge clk) begin
    if (past_rst) begin
      AST_RESET_CLEAR: assert (q == '0 && !ppar_out && !err_oe); // R1
    end
  end

  AST_WIDE_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cfg_layout |-> q[OUT_W-1:IN_W] == '0); // R2

  AST_DUAL_MIRROR: assert property (@(posedge clk) disable iff (rst)
    cfg_layout |-> q[DUAL_W-1:0] == q[2*DUAL_W-1:DUAL_W]); // R3

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |=> $stable(q)); // R4

  AST_ERR_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(err_oe) |=> err_oe); // R6

  AST_FIRST_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !cfg_role |-> !err_oe); // R8

endmodule

bind cfg_regbuf regbuf_checker #(
  .CS_W(CS_W), .OUT_W(OUT_W), .IN_W(IN_W), .DUAL_W(DUAL_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_layout(cfg_layout), .cfg_role(cfg_role),
  .cs_n(cs_n), .q(q), .ppar_out(ppar_out), .err_oe(err_oe)
);

// File: tb/cfg_regbuf_bench.sv
module cfg_regbuf_bench;

  localparam logic [24:0] MW = 25'h03F_FFFF; // checked bits, wide layout (R5)
  localparam logic [24:0] MD = 25'h000_0FFF; // checked bits, split layout (R5)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_layout = 1'b0;
  logic        cfg_role = 1'b1;
  logic [1:0]  cs_n = 2'b00;
  logic [24:0] d = 25'h1AB_CDEF;
  logic        par_in = 1'b1;
  logic        ppar_in = 1'b0;
  logic [27:0] q;
  logic        ppar_out, err_n, err_oe;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  logic nxt_par = 1'b0;

  always #4 clk = ~clk;

  cfg_regbuf u_cfg_regbuf (
    .clk(clk), .rst(rst), .cfg_layout(cfg_layout), .cfg_role(cfg_role),
    .cs_n(cs_n), .d(d), .par_in(par_in), .ppar_in(ppar_in),
    .q(q), .ppar_out(ppar_out), .err_n(err_n), .err_oe(err_oe)
  );

  typedef struct {
    logic [27:0] q;
    logic        err;
    logic        pp;
    string       tag;
  } item_t;
  item_t sb[$];

  function automatic logic [27:0] exp_fan(input logic [24:0] w, input logic lay);
    logic [27:0] r;
    r = '0;
    if (lay) begin
      for (int i = 0; i < 14; i++) begin
        r[i]      = w[i];
        r[i + 14] = w[i];
      end
    end else begin
      r[24:0] = w;
    end
    return r;
  endfunction

  function automatic logic good_par(input logic [24:0] w, input logic lay);
    return ^(w & (lay ? MD : MW));
  endfunction

  // Reference model built from the requirements; pushes one expected item per edge.
  logic [27:0] m_q = '0;
  logic [24:0] m_d = '0;
  logic        m_sum = 1'b0, m_vd = 1'b0, m_vs = 1'b0;
  int          m_hold = 0;

  always @(posedge clk) begin
    item_t it;
    logic  mis, nsum;
    if (rst) begin
      m_q = '0; m_d = '0; m_sum = 1'b0; m_vd = 1'b0; m_vs = 1'b0; m_hold = 0;
    end else begin
      mis = m_vs && cfg_role && (m_sum ^ ppar_in);
      if (mis) m_hold = 2;
      else if (m_hold != 0) m_hold = m_hold - 1;
      nsum  = good_par(m_d, cfg_layout) ^ par_in;
      m_vs  = m_vd;
      m_vd  = 1'b1;
      m_sum = nsum;
      if (cs_n != 2'b11) m_q = exp_fan(d, cfg_layout);
      m_d = d;
    end
    it.q = m_q; it.err = (m_hold != 0); it.pp = m_sum; it.tag = tag;
    sb.push_back(it);
  end

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (q !== it.q) begin
        errors++;
        $display("FAIL %s: q=%h expected %h", it.tag, q, it.q);
      end
      checks++;
      if (err_oe !== it.err || err_n !== !it.err) begin
        errors++;
        $display("FAIL %s: err_oe=%b err_n=%b expected err_oe=%b", it.tag, err_oe, err_n, it.err);
      end
      checks++;
      if (ppar_out !== it.pp) begin
        errors++;
        $display("FAIL %s: ppar_out=%b expected %b", it.tag, ppar_out, it.pp);
      end
    end
  end

  task automatic step(input logic [24:0] w, input logic [1:0] cv, input string t);
    @(negedge clk);
    d = w; par_in = nxt_par; cs_n = cv; tag = t;
  endtask

  // Present a word, pay the parity owed for the previous one, queue this word's parity.
  task automatic word(input logic [24:0] w, input logic bad, input logic [1:0] cv, input string t);
    step(w, cv, t);
    nxt_par = good_par(w, cfg_layout) ^ bad;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) word(25'h0, 1'b0, 2'b00, t);
  endtask

  task automatic do_reset(input logic lay, input logic role);
    @(negedge clk);
    rst = 1'b1; tag = "R1"; cfg_layout = lay; cfg_role = role;
    d = 25'h155_5555; par_in = 1'b1; ppar_in = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; d = '0; nxt_par = 1'b0; par_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset(1'b0, 1'b1);
    // R2: wide layout, clean parity
    for (int i = 0; i < 20; i++) word(25'($urandom), 1'b0, 2'($urandom_range(0, 2)), "R2");
    // R5 / R6: single error, back-to-back errors, errors two apart
    word(25'h0AA_5501, 1'b1, 2'b00, "R6");
    idle(5, "R6");
    word(25'h123_4567, 1'b1, 2'b00, "R6");
    word(25'h0F0_F0F0, 1'b1, 2'b00, "R6");
    word(25'h000_0003, 1'b0, 2'b00, "R5");
    word(25'h1FF_FFFF, 1'b1, 2'b00, "R5");
    idle(6, "R5");
    // R7: only unchecked bits toggle, parity stays that of checked bits
    for (int i = 0; i < 6; i++) word({3'($urandom), 22'h0}, 1'b0, 2'b01, "R7");
    idle(4, "R7");
    // R4: both chip selects idle, data keeps changing
    word(25'h0AB_CDEF, 1'b0, 2'b10, "R4");
    for (int i = 0; i < 6; i++) word(25'($urandom), 1'b0, 2'b11, "R4");
    word(25'h135_7913, 1'b0, 2'b01, "R4");
    idle(3, "R4");
    // R3: split layout
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 16; i++) word(25'($urandom), 1'b0, 2'b00, "R3");
    word(25'h1FF_F000, 1'b0, 2'b00, "R7");
    word(25'h000_0001, 1'b1, 2'b00, "R5");
    idle(5, "R5");
    // R8: first role, corrupted parity is never flagged, partial parity still exported
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) word(25'($urandom), i[0], 2'b00, "R8");
    idle(4, "R8");
    // R9: second role fed by a partial parity input
    do_reset(1'b0, 1'b1);
    idle(2, "R9");
    @(negedge clk); ppar_in = 1'b1;
    for (int i = 0; i < 8; i++) word(25'($urandom), 1'b1, 2'b00, "R9");
    word(25'h000_0000, 1'b0, 2'b00, "R9");
    word(25'h000_0000, 1'b0, 2'b00, "R9");
    @(negedge clk); ppar_in = 1'b0;
    idle(5, "R9");
    // R10: stale parity bit at the first edge after reset must not be reported
    @(negedge clk);
    rst = 1'b1; tag = "R1";
    repeat (2) @(negedge clk);
    rst = 1'b0; d = '0; par_in = 1'b1; tag = "R10";
    @(negedge clk);
    par_in = 1'b0; nxt_par = 1'b0;
    idle(6, "R10");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule